// File: doc/BRIEF.md
# Two-Source Non-Maskable Interrupt Priority Controller

This block decides when a processor core enters a non-maskable interrupt handler, and for which source. There are two sources: a rising edge on an asynchronous external pin, and a single-cycle overflow pulse from a watchdog counter. Each source has a pending latch and an in-service bit. A priority input chooses which source ranks higher. A request is taken unless its own handler or the higher-ranked handler is already active. A higher-ranked request can therefore interrupt a lower-ranked handler, and at that point both in-service bits are set.

When a request is taken, the block runs a fixed three-beat entry sequence. First it writes the status word to a stack write port. Next it writes the program counter to the same port. In the last beat it strobes the interrupt-enable clear and loads the chosen source's vector. A return strobe from the core ends the innermost handler. Any held request is then taken. However many requests arrive for a blocked source, they merge into one pending event.

Top module: `nmi_prio_ctrl`

## Requirements
- R1: After reset, both in-service bits are 0 and `stk_we`, `pc_load`, `ie_clr` and `busy` are 0.
- R2: Take a request whose pending latch is set in cycle T. In cycle T+1, `stk_we` is 1 and `stk_wdata` carries `psw_in` zero-extended. In cycle T+2, `stk_we` is 1 and `stk_wdata` carries `pc_in`. In cycle T+3, `ie_clr` and `pc_load` are 1 and `pc_vec` holds the source's vector. A watchdog pulse sampled at clock edge E therefore loads the vector in the cycle that follows edge E+3. No interrupt-enable state gates this sequence.
- R3: One cycle after the vector load, the block sets the in-service bit of the taken source: `insvc_pin` for the pin and `insvc_wdt` for the watchdog. No other event sets an in-service bit.
- R4: The pin passes through a two-stage synchronizer and an edge detector. A single low-to-high transition gives exactly one request, however long the pin then stays high.
- R5: When `wdt_hi_prio` is 1, the watchdog ranks above the pin. When it is 0, the pin ranks above the watchdog. If both latches are pending together, the higher-ranked source is taken first and the other stays pending.
- R6: A source is not taken while its own in-service bit is set, or while the higher-ranked source's in-service bit is set.
- R7: A higher-ranked request is taken while only the lower-ranked handler is in service. Both in-service bits are then 1.
- R8: A `reti` pulse clears the higher-ranked in-service bit if it is set. Otherwise it clears the lower-ranked bit. It never clears both.
- R9: Any number of same-source requests made while that source is blocked produce exactly one entry after the unblocking return.
- R10: A held request starts its entry sequence in the cycle after the return that unblocks it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_pin | input | 1 | Asynchronous external request; a rising edge requests service |
| wdt_ovf | input | 1 | Watchdog overflow, one-cycle pulse |
| wdt_hi_prio | input | 1 | 1: watchdog ranks higher; 0: pin ranks higher |
| reti | input | 1 | Return-from-interrupt strobe |
| psw_in | input | PSW_W | Current status word |
| pc_in | input | PC_W | Program counter to save |
| stk_we | output | 1 | Stack write strobe |
| stk_wdata | output | PC_W | Stack write data |
| ie_clr | output | 1 | Clear the core's interrupt-enable flag |
| pc_load | output | 1 | Load `pc_vec` into the program counter |
| pc_vec | output | PC_W | Handler vector |
| insvc_pin | output | 1 | Pin handler in service |
| insvc_wdt | output | 1 | Watchdog handler in service |
| busy | output | 1 | Entry sequence in progress |

## Verification
The risky overlap is a pin edge and a watchdog pulse reaching their pending latches on the same clock edge. The bench raises the pin and, two edges later (once the synchronizer delay has passed), pulses the watchdog. It does this for both settings of the priority input. It then checks that the first vector loaded is the higher-ranked one, that no second entry occurs while that handler runs, and that the other vector follows the return. A second overlap is a return strobe arriving while both handlers are active. The bench judges it by which in-service bit is left set.

// File: rtl/nmi_pkg.sv
package nmi_pkg;

    localparam int NSRC = 2;

    typedef enum logic [0:0] {
        SRC_PIN = 1'b0,
        SRC_WDT = 1'b1
    } nmi_src_e;

    typedef enum logic [1:0] {
        SQ_IDLE    = 2'd0,
        SQ_PUSH_SW = 2'd1,
        SQ_PUSH_PC = 2'd2,
        SQ_VECT    = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic     valid;
        nmi_src_e src;
    } grant_t;

    function automatic nmi_src_e rank_high(input logic wdt_hi);
        return wdt_hi ? SRC_WDT : SRC_PIN;
    endfunction

    function automatic nmi_src_e rank_low(input logic wdt_hi);
        return wdt_hi ? SRC_PIN : SRC_WDT;
    endfunction

    function automatic logic [NSRC-1:0] src_mask(input nmi_src_e s);
        logic [NSRC-1:0] m;
        m = '0;
        m[s] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/nmi_edge_sync.sv
module nmi_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_async,
    output logic rise
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[CHAIN_W-2:0], pin_async};
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];

endmodule

// File: rtl/nmi_arbiter.sv
module nmi_arbiter
    import nmi_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] req,
    input  logic            wdt_hi,
    input  logic            take,
    input  nmi_src_e        take_src,
    input  logic            set_en,
    input  nmi_src_e        set_src,
    input  logic            ret,
    output grant_t          grant,
    output logic [NSRC-1:0] insvc
);
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] pend_clr;
    logic [NSRC-1:0] svc_clr;
    logic [NSRC-1:0] svc_set;
    nmi_src_e        hi_s, lo_s;
    logic            hi_elig, lo_elig;

    always_comb begin
        hi_s     = rank_high(wdt_hi);
        lo_s     = rank_low(wdt_hi);
        pend_clr = take ? src_mask(take_src) : '0;
        svc_set  = set_en ? src_mask(set_src) : '0;
        svc_clr  = '0;
        if (ret) begin
            if (insvc[hi_s]) svc_clr = src_mask(hi_s);
            else             svc_clr = src_mask(lo_s);
        end
        hi_elig = pend[hi_s] && !insvc[hi_s];
        lo_elig = pend[lo_s] && !insvc[lo_s] && !insvc[hi_s];
        grant.valid = hi_elig || lo_elig;
        grant.src   = hi_elig ? hi_s : lo_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= '0;
            insvc <= '0;
        end else begin
            pend  <= (pend & ~pend_clr) | req;
            insvc <= (insvc & ~svc_clr) | svc_set;
        end
    end

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_chk
            assert_insvc_set_by_entry_R3: assert property (@(posedge clk) disable iff (rst)
                $rose(insvc[i]) |-> $past(set_en && (int'(set_src) == i)));
        end
    endgenerate

    assert_ret_clears_one_R8: assert property (@(posedge clk) disable iff (rst)
        (ret && (&insvc) && !set_en) |=> ($countones(insvc) == 1));

endmodule

// File: rtl/nmi_push_seq.sv
module nmi_push_seq
    import nmi_pkg::*;
#(
    parameter int             PSW_W   = 8,
    parameter int             PC_W    = 16,
    parameter logic [PC_W-1:0] VEC_PIN = 16'h0008,
    parameter logic [PC_W-1:0] VEC_WDT = 16'h000C
) (
    input  logic             clk,
    input  logic             rst,
    input  grant_t           grant,
    input  logic [PSW_W-1:0] psw,
    input  logic [PC_W-1:0]  pc,
    output logic             take,
    output nmi_src_e         take_src,
    output logic             stk_we,
    output logic [PC_W-1:0]  stk_wdata,
    output logic             ie_clr,
    output logic             pc_load,
    output logic [PC_W-1:0]  pc_vec,
    output logic             set_en,
    output nmi_src_e         set_src,
    output logic             busy
);
    localparam int PAD_W = PC_W - PSW_W;

    seq_state_e state;
    nmi_src_e   cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            cur   <= SRC_PIN;
        end else begin
            unique case (state)
                SQ_IDLE: if (take) begin
                    state <= SQ_PUSH_SW;
                    cur   <= take_src;
                end
                SQ_PUSH_SW: state <= SQ_PUSH_PC;
                SQ_PUSH_PC: state <= SQ_VECT;
                SQ_VECT:    state <= SQ_IDLE;
                default:    state <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        take      = (state == SQ_IDLE) && grant.valid;
        take_src  = grant.src;
        busy      = (state != SQ_IDLE);
        stk_we    = (state == SQ_PUSH_SW) || (state == SQ_PUSH_PC);
        stk_wdata = (state == SQ_PUSH_PC) ? pc : {{PAD_W{1'b0}}, psw};
        pc_load   = (state == SQ_VECT);
        ie_clr    = pc_load;
        pc_vec    = (cur == SRC_WDT) ? VEC_WDT : VEC_PIN;
        set_en    = pc_load;
        set_src   = cur;
    end

    assert_push_before_vector_R2: assert property (@(posedge clk) disable iff (rst)
        pc_load |-> ($past(stk_we) && $past(stk_we, 2)));

    assert_no_push_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
        stk_we |-> busy);

endmodule

// File: rtl/nmi_prio_ctrl.sv
module nmi_prio_ctrl
    import nmi_pkg::*;
#(
    parameter int              PSW_W       = 8,
    parameter int              PC_W        = 16,
    parameter int              SYNC_STAGES = 2,
    parameter logic [PC_W-1:0] VEC_PIN     = 16'h0008,
    parameter logic [PC_W-1:0] VEC_WDT     = 16'h000C
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             nmi_pin,
    input  logic             wdt_ovf,
    input  logic             wdt_hi_prio,
    input  logic             reti,
    input  logic [PSW_W-1:0] psw_in,
    input  logic [PC_W-1:0]  pc_in,
    output logic             stk_we,
    output logic [PC_W-1:0]  stk_wdata,
    output logic             ie_clr,
    output logic             pc_load,
    output logic [PC_W-1:0]  pc_vec,
    output logic             insvc_pin,
    output logic             insvc_wdt,
    output logic             busy
);
    logic            pin_rise;
    logic [NSRC-1:0] req;
    logic [NSRC-1:0] insvc;
    grant_t          grant;
    logic            take, set_en;
    nmi_src_e        take_src, set_src;

    nmi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pin_async (nmi_pin),
        .rise      (pin_rise)
    );

    always_comb begin
        req          = '0;
        req[SRC_PIN] = pin_rise;
        req[SRC_WDT] = wdt_ovf;
    end

    nmi_arbiter u_arb (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .wdt_hi   (wdt_hi_prio),
        .take     (take),
        .take_src (take_src),
        .set_en   (set_en),
        .set_src  (set_src),
        .ret      (reti),
        .grant    (grant),
        .insvc    (insvc)
    );

    nmi_push_seq #(
        .PSW_W   (PSW_W),
        .PC_W    (PC_W),
        .VEC_PIN (VEC_PIN),
        .VEC_WDT (VEC_WDT)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .grant     (grant),
        .psw       (psw_in),
        .pc        (pc_in),
        .take      (take),
        .take_src  (take_src),
        .stk_we    (stk_we),
        .stk_wdata (stk_wdata),
        .ie_clr    (ie_clr),
        .pc_load   (pc_load),
        .pc_vec    (pc_vec),
        .set_en    (set_en),
        .set_src   (set_src),
        .busy      (busy)
    );

    assign insvc_pin = insvc[SRC_PIN];
    assign insvc_wdt = insvc[SRC_WDT];

    assert_no_reentry_pin_R6: assert property (@(posedge clk) disable iff (rst)
        (pc_load && pc_vec == VEC_PIN) |-> !insvc_pin);

    assert_no_reentry_wdt_R6: assert property (@(posedge clk) disable iff (rst)
        (pc_load && pc_vec == VEC_WDT) |-> !insvc_wdt);

endmodule

// File: tb/sim_nmi_prio_ctrl.sv
module sim_nmi_prio_ctrl;

    localparam int          PSW_W = 8;
    localparam int          PC_W  = 16;
    localparam logic [15:0] V_PIN = 16'h0008;
    localparam logic [15:0] V_WDT = 16'h000C;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nmi_pin = 1'b0, wdt_ovf = 1'b0, wdt_hi_prio = 1'b0, reti = 1'b0;
    logic [PSW_W-1:0] psw_in = 8'h5A;
    logic [PC_W-1:0]  pc_in  = 16'h1234;
    logic             stk_we, ie_clr, pc_load, insvc_pin, insvc_wdt, busy;
    logic [PC_W-1:0]  stk_wdata, pc_vec;

    int tests = 0, fails = 0, cyc = 0;
    int ack_cnt = 0, ack_cyc = 0, ie_cnt = 0, wr_cnt = 0;
    logic [15:0] last_vec = '0;
    logic [15:0] wlog [0:63];
    bit done = 0;

    always #5 clk = ~clk;

    nmi_prio_ctrl u0 (
        .clk(clk), .rst(rst), .nmi_pin(nmi_pin), .wdt_ovf(wdt_ovf),
        .wdt_hi_prio(wdt_hi_prio), .reti(reti), .psw_in(psw_in), .pc_in(pc_in),
        .stk_we(stk_we), .stk_wdata(stk_wdata), .ie_clr(ie_clr), .pc_load(pc_load),
        .pc_vec(pc_vec), .insvc_pin(insvc_pin), .insvc_wdt(insvc_wdt), .busy(busy)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            if (stk_we) begin
                wlog[wr_cnt[5:0]] = stk_wdata;
                wr_cnt = wr_cnt + 1;
            end
            if (pc_load) begin
                ack_cnt  = ack_cnt + 1;
                ack_cyc  = cyc;
                last_vec = pc_vec;
            end
            if (ie_clr) ie_cnt = ie_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_wdt;
        @(negedge clk) wdt_ovf = 1'b1;
        @(negedge clk) wdt_ovf = 1'b0;
    endtask

    task automatic pulse_ret;
        @(negedge clk) reti = 1'b1;
        @(negedge clk) reti = 1'b0;
    endtask

    task automatic t_reset;
        chk(!insvc_pin && !insvc_wdt, "R1 insvc", {insvc_pin, insvc_wdt}, 0);
        chk(!stk_we && !pc_load && !ie_clr && !busy, "R1 strobes",
            {stk_we, pc_load, ie_clr, busy}, 0);
    endtask

    task automatic t_wdt_entry;
        int c0, a0, w0;
        wdt_hi_prio = 1'b0;
        a0 = ack_cnt; w0 = wr_cnt;
        @(negedge clk);
        c0 = cyc;
        wdt_ovf = 1'b1;
        @(negedge clk) wdt_ovf = 1'b0;
        tick(6);
        chk(wr_cnt - w0 == 2, "R2 write count", wr_cnt - w0, 2);
        chk(wlog[w0[5:0]] == 16'h005A, "R2 first push status", wlog[w0[5:0]], 16'h005A);
        chk(wlog[(w0 + 1) & 63] == 16'h1234, "R2 second push pc", wlog[(w0 + 1) & 63], 16'h1234);
        chk(ack_cnt - a0 == 1 && last_vec == V_WDT, "R2 wdt vector", last_vec, V_WDT);
        chk(ack_cyc - c0 == 4, "R2 latency", ack_cyc - c0, 4);
        chk(ie_cnt == ack_cnt, "R2 ie_clr with vector", ie_cnt, ack_cnt);
        chk(insvc_wdt && !insvc_pin, "R3 wdt in-service bit", {insvc_pin, insvc_wdt}, 1);
        pulse_ret();
        chk(!insvc_wdt, "R8 ret clears wdt", insvc_wdt, 0);
    endtask

    task automatic t_pin_level;
        int a0;
        a0 = ack_cnt;
        @(negedge clk) nmi_pin = 1'b1;
        tick(20);
        chk(ack_cnt - a0 == 1, "R4 one entry per edge", ack_cnt - a0, 1);
        chk(last_vec == V_PIN, "R4 pin vector", last_vec, V_PIN);
        chk(insvc_pin && !insvc_wdt, "R3 pin in-service bit", {insvc_pin, insvc_wdt}, 2);
        nmi_pin = 1'b0;
        pulse_ret();
        tick(8);
        chk(!insvc_pin && ack_cnt - a0 == 1, "R4 no extra entry", ack_cnt - a0, 1);
    endtask

    task automatic t_same_cycle(input bit wdt_hi);
        int a0;
        logic [15:0] v_hi, v_lo;
        v_hi = wdt_hi ? V_WDT : V_PIN;
        v_lo = wdt_hi ? V_PIN : V_WDT;
        wdt_hi_prio = wdt_hi;
        a0 = ack_cnt;
        @(negedge clk) nmi_pin = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk) wdt_ovf = 1'b1;
        @(negedge clk) wdt_ovf = 1'b0;
        tick(12);
        chk(ack_cnt - a0 == 1 && last_vec == v_hi, "R5 higher taken first", last_vec, v_hi);
        chk(insvc_wdt == wdt_hi && insvc_pin == !wdt_hi, "R6 lower held",
            {insvc_pin, insvc_wdt}, wdt_hi ? 1 : 2);
        pulse_ret();
        tick(6);
        chk(ack_cnt - a0 == 2 && last_vec == v_lo, "R10 held taken after ret", last_vec, v_lo);
        chk(insvc_wdt == !wdt_hi && insvc_pin == wdt_hi, "R5 lower now in service",
            {insvc_pin, insvc_wdt}, wdt_hi ? 2 : 1);
        nmi_pin = 1'b0;
        pulse_ret();
        chk(!insvc_pin && !insvc_wdt, "R8 all clear", {insvc_pin, insvc_wdt}, 0);
    endtask

    task automatic t_preempt;
        int a0;
        wdt_hi_prio = 1'b1;
        a0 = ack_cnt;
        @(negedge clk) nmi_pin = 1'b1;
        tick(10);
        nmi_pin = 1'b0;
        pulse_wdt();
        tick(6);
        chk(ack_cnt - a0 == 2 && last_vec == V_WDT, "R7 preempt vector", last_vec, V_WDT);
        chk(insvc_pin && insvc_wdt, "R7 both in service", {insvc_pin, insvc_wdt}, 3);
        pulse_ret();
        chk(insvc_pin && !insvc_wdt, "R8 ret clears higher only", {insvc_pin, insvc_wdt}, 2);
        pulse_ret();
        chk(!insvc_pin && !insvc_wdt, "R8 second ret", {insvc_pin, insvc_wdt}, 0);
    endtask

    task automatic t_lower_blocked;
        int a0;
        wdt_hi_prio = 1'b0;
        a0 = ack_cnt;
        @(negedge clk) nmi_pin = 1'b1;
        tick(10);
        nmi_pin = 1'b0;
        pulse_wdt();
        tick(10);
        chk(ack_cnt - a0 == 1 && !insvc_wdt, "R6 lower blocked by higher", ack_cnt - a0, 1);
        pulse_ret();
        tick(6);
        chk(ack_cnt - a0 == 2 && last_vec == V_WDT, "R10 lower after ret", last_vec, V_WDT);
        pulse_ret();
    endtask

    task automatic t_collapse;
        int a0;
        wdt_hi_prio = 1'b0;
        a0 = ack_cnt;
        pulse_wdt();
        tick(6);
        for (int k = 0; k < 3; k++) begin
            pulse_wdt();
            tick(1);
        end
        tick(8);
        chk(ack_cnt - a0 == 1, "R6 same source blocked", ack_cnt - a0, 1);
        pulse_ret();
        tick(6);
        chk(ack_cnt - a0 == 2 && insvc_wdt, "R9 single entry after ret", ack_cnt - a0, 2);
        pulse_ret();
        tick(10);
        chk(ack_cnt - a0 == 2 && !insvc_wdt, "R9 no further entry", ack_cnt - a0, 2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        tick(3);
        @(negedge clk) rst = 1'b0;
        tick(1);
        t_reset();
        t_wdt_entry();
        t_pin_level();
        t_same_cycle(1'b1);
        t_same_cycle(1'b0);
        t_preempt();
        t_lower_blocked();
        t_collapse();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule